// File: doc/BRIEF.md
# Slave DMA Burst Engine

This block is the device-side end of a system DMA channel. It sits in front of a local, word-organised buffer RAM and answers an external DMA controller through a request/acknowledge pair. Software sets a buffer byte address, a direction, a burst size and a total length (both in bytes, whatever the bus width), and a 16-bit or 32-bit bus mode, then writes a start command. The engine raises its request line for each burst, moves one bus word per acknowledged cycle between the host data pins and the RAM, and advances its own address and byte counters.

The acknowledge may be withdrawn at any cycle. The engine then stops where it is, so the host can make other accesses and resume later. Lengths that are not whole bus words are padded on the bus. On writes, byte enables keep the RAM bytes past the programmed length untouched. Completion sets a sticky flag, which drives the interrupt line when its enable bit is set.

Top module: `dma_slave_engine`

## Requirements
- R1: Each acknowledged bus cycle (a beat) in an active burst moves one bus word at the current address. The address then steps by 4 bytes in 32-bit mode or 2 in 16-bit mode. `mem_addr` is the byte address divided by 4.
- R2: On start, the low address bits that the bus mode cannot express are cleared: bits 1:0 in 32-bit mode, bit 0 in 16-bit mode.
- R3: Length and burst size are byte counts. A length L takes ceil(L/4) beats in 32-bit mode and ceil(L/2) in 16-bit mode.
- R4: The request is active during a burst. After the beat that finishes a burst (burst size rounded up to the bus step), it is inactive for exactly one cycle if bytes remain. It goes inactive after the final beat and stays there. A burst size of 0 means one burst for the whole transfer.
- R5: While the acknowledge is inactive, no beat happens, and the address and remaining count are held.
- R6: Byte lanes are little-endian (lane k = bits 8k+7:8k). In 16-bit mode, byte-address bit 1 picks the upper half-word and the bus data is copied to both halves. On writes, `mem_be` enables only bytes whose offset from the start is below the programmed length.
- R7: Completion sets a flag (status register 5, bit 1), cleared by writing 1 to that bit. If completion and the clear fall in the same cycle, completion wins. `irq` = flag AND bit 3 of register 4.
- R8: Mode register 0 holds bit 0 = write (bus to memory), bit 1 = 32-bit mode, bit 2 = request active-high, bit 3 = acknowledge active-high. Each polarity bit sets the active level of its pin.
- R9: In read mode, a beat issues `mem_re`. One cycle later `bus_dvalid` is high and `bus_dout` holds the word (32-bit mode) or the selected half-word in bits 15:0 (16-bit mode).
- R10: Writing 1 to bit 0 of command register 6 while busy has no effect. A start with length 0 sets the flag at once and never raises the request.
- R11: After reset, the mode register reads 0xE, status reads 0, `irq` is low and the request is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| dreq | output | 1 | DMA request pin, programmable polarity |
| dack | input | 1 | DMA acknowledge pin, programmable polarity |
| bus_din | input | 32 | Host write data (bits 15:0 in 16-bit mode) |
| bus_dout | output | 32 | Host read data |
| bus_dvalid | output | 1 | Read data valid |
| mem_addr | output | ADDR_W-2 | RAM word address |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe |
| mem_be | output | 4 | RAM byte enables |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data, one cycle after `mem_re` |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
Two events can land in the same clock edge. One is the final beat of a transfer, which sets the completion flag. The other is a software write-one-to-clear of that same flag. The bench provokes this by watching its reference model and issuing the clearing register write in exactly the cycle where the acknowledged beat leaves no padded bytes. It then expects the flag and `irq` to stay set afterwards. A second overlap is a start command arriving while a transfer is still paused. That is judged by checking that every later `mem_addr` still follows the first transfer.

// File: rtl/dse_pkg.sv
package dse_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_GAP  = 2'd2
   } dse_state_e;

   typedef struct packed {
      logic dack_hi;
      logic dreq_hi;
      logic wide;
      logic dir_wr;
   } dse_mode_t;

   localparam logic [2:0] RG_MODE  = 3'd0;
   localparam logic [2:0] RG_BASE  = 3'd1;
   localparam logic [2:0] RG_LEN   = 3'd2;
   localparam logic [2:0] RG_BURST = 3'd3;
   localparam logic [2:0] RG_IEN   = 3'd4;
   localparam logic [2:0] RG_STAT  = 3'd5;
   localparam logic [2:0] RG_CMD   = 3'd6;

   localparam int IEN_EOT_BIT  = 3;
   localparam int STAT_FLAG_BIT = 1;
endpackage

// File: rtl/dse_regs.sv
module dse_regs
   import dse_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int LEN_W     = 13,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              busy,
   input  logic              done,
   output dse_mode_t         mode,
   output logic [ADDR_W-1:0] base,
   output logic [LEN_W-1:0]  len,
   output logic [LEN_W-1:0]  burst,
   output logic              start_go,
   output logic              irq
);
   dse_mode_t         mode_q;
   logic [ADDR_W-1:0] base_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  burst_q;
   logic              ie_q;
   logic              flag_q;
   logic              clr_hit;
   logic              unused_wbits;

   assign unused_wbits = ^cfg_wdata;

   generate
      if (NARROW_EN) begin : g_both_widths
         assign mode = mode_q;
      end else begin : g_wide_only
         assign mode = '{dack_hi: mode_q.dack_hi, dreq_hi: mode_q.dreq_hi,
                         wide: 1'b1, dir_wr: mode_q.dir_wr};
      end
   endgenerate

   assign start_go = cfg_we && (cfg_addr == RG_CMD) && cfg_wdata[0] && !busy;
   assign clr_hit  = cfg_we && (cfg_addr == RG_STAT) && cfg_wdata[STAT_FLAG_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= '{dack_hi: 1'b1, dreq_hi: 1'b1, wide: 1'b1, dir_wr: 1'b0};
         base_q  <= '0;
         len_q   <= '0;
         burst_q <= '0;
         ie_q    <= 1'b0;
      end else if (cfg_we) begin
         case (cfg_addr)
            RG_MODE:  mode_q  <= dse_mode_t'(cfg_wdata[3:0]);
            RG_BASE:  base_q  <= cfg_wdata[ADDR_W-1:0];
            RG_LEN:   len_q   <= cfg_wdata[LEN_W-1:0];
            RG_BURST: burst_q <= cfg_wdata[LEN_W-1:0];
            RG_IEN:   ie_q    <= cfg_wdata[IEN_EOT_BIT];
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (done)    flag_q <= 1'b1;
      else if (clr_hit) flag_q <= 1'b0;
   end

   assign base  = base_q;
   assign len   = len_q;
   assign burst = burst_q;
   assign irq   = flag_q && ie_q;

   always_comb begin
      case (cfg_addr)
         RG_MODE:  cfg_rdata = {28'd0, mode};
         RG_BASE:  cfg_rdata = 32'(base_q);
         RG_LEN:   cfg_rdata = 32'(len_q);
         RG_BURST: cfg_rdata = 32'(burst_q);
         RG_IEN:   cfg_rdata = {28'd0, ie_q, 3'd0};
         RG_STAT:  cfg_rdata = {30'd0, flag_q, busy};
         default:  cfg_rdata = '0;
      endcase
   end

   assert_flag_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> flag_q);
   assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_go && len_q != '0) |=> busy);
endmodule

// File: rtl/dse_ctrl.sv
module dse_ctrl
   import dse_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int LEN_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_go,
   input  logic              mode_wide,
   input  logic              mode_dir,
   input  logic [ADDR_W-1:0] base,
   input  logic [LEN_W-1:0]  len,
   input  logic [LEN_W-1:0]  burst,
   input  logic              dack_act,
   output logic              busy,
   output logic              dreq_act,
   output logic              beat,
   output logic              done,
   output logic [ADDR_W-1:0] addr,
   output logic [LEN_W:0]    real_left,
   output logic              wide_q,
   output logic              dir_q
);
   localparam int CW = LEN_W + 1;

   dse_state_e        st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CW-1:0]     pad_q, real_q, bl_q, bsz_q;
   logic              use_wide;
   logic [CW-1:0]     step_c;
   logic [ADDR_W-1:0] astep;
   logic [CW-1:0]     pad_new, bsz_new;

   function automatic logic [CW-1:0] round_up(input logic [CW-1:0] v, input logic w);
      logic [CW-1:0] m;
      m = w ? CW'(3) : CW'(1);
      return (v + m) & ~m;
   endfunction

   function automatic logic [CW-1:0] burst_pick(input logic [CW-1:0] b, input logic [CW-1:0] p);
      return (b == '0 || b > p) ? p : b;
   endfunction

   assign use_wide = (st_q == ST_IDLE) ? mode_wide : wide_q;
   assign step_c   = use_wide ? CW'(4) : CW'(2);
   assign astep    = use_wide ? ADDR_W'(4) : ADDR_W'(2);
   assign pad_new  = round_up({1'b0, len}, mode_wide);
   assign bsz_new  = round_up({1'b0, burst}, mode_wide);

   assign busy     = (st_q != ST_IDLE);
   assign dreq_act = (st_q == ST_REQ);
   assign beat     = (st_q == ST_REQ) && dack_act;
   assign done     = (beat && pad_q == step_c) ||
                     (start_go && st_q == ST_IDLE && pad_new == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         addr_q <= '0;
         pad_q  <= '0;
         real_q <= '0;
         bl_q   <= '0;
         bsz_q  <= '0;
         wide_q <= 1'b1;
         dir_q  <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (start_go) begin
               addr_q <= base & ~(astep - ADDR_W'(1));
               pad_q  <= pad_new;
               real_q <= {1'b0, len};
               bsz_q  <= bsz_new;
               bl_q   <= burst_pick(bsz_new, pad_new);
               wide_q <= mode_wide;
               dir_q  <= mode_dir;
               if (pad_new != '0) st_q <= ST_REQ;
            end
            ST_REQ: if (beat) begin
               addr_q <= addr_q + astep;
               pad_q  <= pad_q - step_c;
               real_q <= (real_q > step_c) ? real_q - step_c : '0;
               bl_q   <= bl_q - step_c;
               if (pad_q == step_c)     st_q <= ST_IDLE;
               else if (bl_q == step_c) st_q <= ST_GAP;
            end
            ST_GAP: begin
               bl_q <= burst_pick(bsz_q, pad_q);
               st_q <= ST_REQ;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign addr      = addr_q;
   assign real_left = real_q;

   assert_hold_on_pause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_REQ && !dack_act) |=> (addr_q == $past(addr_q) && pad_q == $past(pad_q)));
   assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (wide_q ? (addr_q[1:0] == 2'b00) : (addr_q[0] == 1'b0)));
   assert_req_low_after_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !dreq_act);
   assert_gap_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_GAP) |=> dreq_act);
endmodule

// File: rtl/dse_lanes.sv
module dse_lanes #(
   parameter int ADDR_W = 12,
   parameter int LEN_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat,
   input  logic              wide,
   input  logic              dir_wr,
   input  logic [ADDR_W-3:0] word_addr,
   input  logic              lane_hi,
   input  logic [LEN_W:0]    real_left,
   input  logic [31:0]       bus_din,
   input  logic [31:0]       mem_rdata,
   output logic [ADDR_W-3:0] mem_addr,
   output logic              mem_we,
   output logic              mem_re,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   output logic [31:0]       bus_dout,
   output logic              bus_dvalid
);
   localparam int CW    = LEN_W + 1;
   localparam int LANES = 4;

   logic [2:0]       nvalid;
   logic [LANES-1:0] be_c;
   logic             rd_v_q, rd_hi_q, rd_wide_q;

   always_comb begin
      if (wide) nvalid = (real_left >= CW'(4)) ? 3'd4 : real_left[2:0];
      else      nvalid = (real_left >= CW'(2)) ? 3'd2 : real_left[2:0];
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [2:0] POS_W = 3'(i);
      localparam logic [2:0] POS_N = 3'(i % 2);
      localparam logic       HALF  = (i >= 2);
      assign be_c[i] = wide ? (POS_W < nvalid)
                            : ((lane_hi == HALF) && (POS_N < nvalid));
   end

   assign mem_addr  = word_addr;
   assign mem_we    = beat && dir_wr;
   assign mem_re    = beat && !dir_wr;
   assign mem_be    = be_c;
   assign mem_wdata = wide ? bus_din : {bus_din[15:0], bus_din[15:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_v_q    <= 1'b0;
         rd_hi_q   <= 1'b0;
         rd_wide_q <= 1'b1;
      end else begin
         rd_v_q <= mem_re;
         if (mem_re) begin
            rd_hi_q   <= lane_hi;
            rd_wide_q <= wide;
         end
      end
   end

   assign bus_dvalid = rd_v_q;
   assign bus_dout   = !rd_v_q  ? 32'd0 :
                       rd_wide_q ? mem_rdata :
                       {16'd0, (rd_hi_q ? mem_rdata[31:16] : mem_rdata[15:0])};

   assert_narrow_one_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !wide) |-> (mem_be[3:2] == 2'b00 || mem_be[1:0] == 2'b00));
   assert_be_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_be != 4'd0 && $countones(mem_be) <= (wide ? 4 : 2)));
   assert_read_returns_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> bus_dvalid);
endmodule

// File: rtl/dma_slave_engine.sv
module dma_slave_engine
   import dse_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int LEN_W     = 13,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic              dreq,
   input  logic              dack,
   input  logic [31:0]       bus_din,
   output logic [31:0]       bus_dout,
   output logic              bus_dvalid,
   output logic [ADDR_W-3:0] mem_addr,
   output logic              mem_we,
   output logic              mem_re,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              irq
);
   generate
      if (ADDR_W < 4 || ADDR_W > 31) begin : g_bad_addr_w
         $error("dma_slave_engine: ADDR_W must lie in 4..31");
      end
      if (LEN_W < 3 || LEN_W > 30) begin : g_bad_len_w
         $error("dma_slave_engine: LEN_W must lie in 3..30");
      end
   endgenerate

   dse_mode_t         mode;
   logic [ADDR_W-1:0] base;
   logic [LEN_W-1:0]  len, burst;
   logic              start_go, busy, done, beat, dreq_act, dack_act;
   logic [ADDR_W-1:0] addr;
   logic [LEN_W:0]    real_left;
   logic              wide_q, dir_q;

   assign dack_act = (dack == mode.dack_hi);
   assign dreq     = mode.dreq_hi ? dreq_act : !dreq_act;

   dse_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NARROW_EN(NARROW_EN)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy), .done(done),
      .mode(mode), .base(base), .len(len), .burst(burst),
      .start_go(start_go), .irq(irq)
   );

   dse_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_go(start_go), .mode_wide(mode.wide),
      .mode_dir(mode.dir_wr), .base(base), .len(len), .burst(burst),
      .dack_act(dack_act), .busy(busy), .dreq_act(dreq_act), .beat(beat),
      .done(done), .addr(addr), .real_left(real_left), .wide_q(wide_q),
      .dir_q(dir_q)
   );

   dse_lanes #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_lanes (
      .clk(clk), .rst_n(rst_n), .beat(beat), .wide(wide_q), .dir_wr(dir_q),
      .word_addr(addr[ADDR_W-1:2]), .lane_hi(addr[1]), .real_left(real_left),
      .bus_din(bus_din), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
      .mem_we(mem_we), .mem_re(mem_re), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .bus_dout(bus_dout), .bus_dvalid(bus_dvalid)
   );

   assert_req_polarity_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (dreq == !mode.dreq_hi));
endmodule

// File: tb/tb_dma_slave_engine.sv
module tb_dma_slave_engine;
   localparam int AW = 12;
   localparam int LW = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic          dreq;
   logic          dack = 1'b0;
   logic [31:0]   bus_din = '0;
   logic [31:0]   bus_dout;
   logic          bus_dvalid;
   logic [AW-3:0] mem_addr;
   logic          mem_we, mem_re;
   logic [3:0]    mem_be;
   logic [31:0]   mem_wdata;
   logic [31:0]   mem_rdata = '0;
   logic          irq;

   dma_slave_engine #(.ADDR_W(AW), .LEN_W(LW)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq(dreq), .dack(dack),
      .bus_din(bus_din), .bus_dout(bus_dout), .bus_dvalid(bus_dvalid),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
   );

   int total = 0;
   int bad = 0;
   int obs_beats = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Buffer RAM and byte-level expectation of its contents
   logic [31:0] mem [0:1023];
   logic [7:0]  refb [0:4095];

   initial begin
      for (int w = 0; w < 1024; w++) begin
         mem[w] = 32'h5A000000 | (w * 32'h00010101);
         for (int k = 0; k < 4; k++) refb[4*w+k] = mem[w][8*k +: 8];
      end
   end

   always @(posedge clk) begin
      if (mem_we)
         for (int k = 0; k < 4; k++)
            if (mem_be[k]) mem[mem_addr][8*k +: 8] <= mem_wdata[8*k +: 8];
      if (mem_re) mem_rdata <= mem[mem_addr];
   end

   // Behavioural reference model
   bit m_busy, m_gap, m_flag, m_ie, m_dirw, m_wide, m_dreq_hi, m_dack_hi;
   bit m_run_dirw;
   int m_addr, m_base, m_pad, m_real, m_bl, m_bsz, m_step, m_len, m_burst, m_start;
   int m_xlen;
   bit exp_dv;
   logic [31:0] exp_do;

   function automatic int rup(input int v, input int s);
      return ((v + s - 1) / s) * s;
   endfunction

   always @(posedge clk) begin : model
      bit was_busy, bt, fin;
      int s;
      was_busy = m_busy;
      fin = 1'b0;
      if (!rst_n) begin
         m_busy = 0; m_gap = 0; m_flag = 0; m_ie = 0; m_dirw = 0; m_wide = 1;
         m_dreq_hi = 1; m_dack_hi = 1; m_start = 0; m_len = 0; m_burst = 0;
         m_step = 4; exp_dv = 0; exp_do = '0;
      end else begin
         s = m_step;
         bt = m_busy && !m_gap && (dack == m_dack_hi);
         exp_dv = bt && !m_run_dirw;
         if (bt && !m_run_dirw)
            exp_do = (s == 4) ? mem[m_addr / 4]
                              : {16'd0, mem[m_addr / 4][16*((m_addr / 2) % 2) +: 16]};
         if (bt && m_run_dirw)
            for (int k = 0; k < s; k++)
               if (m_addr + k - m_base < m_xlen) refb[m_addr + k] = bus_din[8*(k % 2 + ((s == 4) ? (k / 2) * 2 : 0)) +: 8];
         if (m_busy) begin
            if (m_gap) begin
               m_gap = 0;
               m_bl = (m_bsz == 0 || m_bsz > m_pad) ? m_pad : m_bsz;
            end else if (bt) begin
               m_addr += s; m_pad -= s; m_bl -= s;
               m_real = (m_real > s) ? m_real - s : 0;
               if (m_pad == 0) begin m_busy = 0; fin = 1; end
               else if (m_bl == 0) m_gap = 1;
            end
         end
         if (cfg_we) begin
            case (cfg_addr)
               3'd0: begin
                  m_dirw = cfg_wdata[0]; m_wide = cfg_wdata[1];
                  m_dreq_hi = cfg_wdata[2]; m_dack_hi = cfg_wdata[3];
               end
               3'd1: m_start = int'(cfg_wdata[AW-1:0]);
               3'd2: m_len = int'(cfg_wdata[LW-1:0]);
               3'd3: m_burst = int'(cfg_wdata[LW-1:0]);
               3'd4: m_ie = cfg_wdata[3];
               3'd6: if (cfg_wdata[0] && !was_busy) begin
                  s = m_wide ? 4 : 2;
                  m_step = s;
                  m_base = m_start & ~(s - 1);
                  m_addr = m_base;
                  m_pad = rup(m_len, s);
                  m_real = m_len;
                  m_xlen = m_len;
                  m_bsz = rup(m_burst, s);
                  m_run_dirw = m_dirw;
                  if (m_pad == 0) fin = 1;
                  else begin
                     m_busy = 1; m_gap = 0;
                     m_bl = (m_bsz == 0 || m_bsz > m_pad) ? m_pad : m_bsz;
                  end
               end
               default: ;
            endcase
         end
         if (fin) m_flag = 1;
         else if (cfg_we && cfg_addr == 3'd5 && cfg_wdata[1]) m_flag = 0;
      end
   end

   // Per-cycle comparison, away from the rising edge
   always @(negedge clk) begin : compare
      bit act, bt;
      int n;
      logic [3:0] eb;
      #2;
      if (rst_n) begin
         act = m_busy && !m_gap;
         bt = act && (dack == m_dack_hi);
         chk(dreq == (m_dreq_hi ? act : !act), "R4/R8", "dreq", 32'(dreq),
             32'(m_dreq_hi ? act : !act));
         chk(mem_we == (bt && m_run_dirw), "R1/R5", "mem_we", 32'(mem_we), 32'(bt && m_run_dirw));
         chk(mem_re == (bt && !m_run_dirw), "R9", "mem_re", 32'(mem_re), 32'(bt && !m_run_dirw));
         if (mem_we || mem_re) obs_beats++;
         if (bt)
            chk(mem_addr == 10'(m_addr / 4), "R1/R2", "mem_addr", 32'(mem_addr), 32'(m_addr / 4));
         if (bt && m_run_dirw) begin
            n = (m_real < m_step) ? m_real : m_step;
            eb = '0;
            for (int k = 0; k < n; k++) eb[(m_addr % 4) + k] = 1'b1;
            chk(mem_be == eb, "R6", "mem_be", 32'(mem_be), 32'(eb));
         end
         chk(irq == (m_flag && m_ie), "R7", "irq", 32'(irq), 32'(m_flag && m_ie));
         chk(bus_dvalid == exp_dv, "R9", "bus_dvalid", 32'(bus_dvalid), 32'(exp_dv));
         if (exp_dv) chk(bus_dout == exp_do, "R9", "bus_dout", bus_dout, exp_do);
      end
   end

   task automatic wcfg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      if (a == 3'd0) dack = !d[3];
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rcfg(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      cfg_we = 1'b0; cfg_addr = a;
      #1 v = cfg_rdata;
   endtask

   task automatic run(input int pm, input bit clr_last, input int exp_beats, input string req);
      int c = 0;
      obs_beats = 0;
      while (m_busy && c < 4000) begin
         @(negedge clk);
         dack = ((c % pm) == pm - 1) ? !m_dack_hi : m_dack_hi;
         bus_din = 32'(c + 1) * 32'h9E3779B1;
         if (clr_last && !m_gap && m_pad == m_step && dack == m_dack_hi) begin
            cfg_we = 1'b1; cfg_addr = 3'd5; cfg_wdata = 32'h2;
         end else cfg_we = 1'b0;
         c++;
      end
      @(negedge clk);
      dack = !m_dack_hi; cfg_we = 1'b0;
      @(negedge clk);
      chk(obs_beats == exp_beats, req, "beat count", 32'(obs_beats), 32'(exp_beats));
   endtask

   task automatic mem_compare(input string req);
      int errs = 0;
      for (int w = 0; w < 64; w++)
         if (mem[w] != {refb[4*w+3], refb[4*w+2], refb[4*w+1], refb[4*w]}) errs++;
      chk(errs == 0, req, "memory words differing", 32'(errs), 32'd0);
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finish");
      summary();
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      dack = 1'b0;
      // R11 reset state
      rcfg(3'd0, v); chk(v == 32'hE, "R11", "mode reset", v, 32'hE);
      rcfg(3'd5, v); chk(v == 32'h0, "R11", "status reset", v, 32'h0);
      chk(irq == 1'b0, "R11", "irq reset", 32'(irq), 32'd0);
      chk(dreq == 1'b0, "R11", "dreq reset", 32'(dreq), 32'd0);

      // A: 32-bit write, misaligned start, odd length, bursts of 8, pauses (R1 R2 R3 R4 R5 R6 R7)
      wcfg(3'd0, 32'hF); wcfg(3'd1, 32'h11); wcfg(3'd2, 32'd10);
      wcfg(3'd3, 32'd8); wcfg(3'd4, 32'h8); wcfg(3'd6, 32'h1);
      run(5, 1'b0, 3, "R3");
      mem_compare("R6");
      chk(irq == 1'b1, "R7", "irq after end", 32'(irq), 32'd1);
      wcfg(3'd5, 32'h2);
      rcfg(3'd5, v); chk(v == 32'h0, "R7", "flag after clear", v, 32'h0);

      // B: 16-bit write, half-word start, completion and clear in one cycle (R6 R7)
      wcfg(3'd0, 32'hD); wcfg(3'd1, 32'h42); wcfg(3'd2, 32'd7);
      wcfg(3'd3, 32'd4); wcfg(3'd6, 32'h1);
      run(3, 1'b1, 4, "R3");
      mem_compare("R6");
      rcfg(3'd5, v); chk(v == 32'h2, "R7", "set beats clear", v, 32'h2);
      wcfg(3'd5, 32'h2);

      // C: 32-bit read, burst 0 = single burst (R4 R9)
      wcfg(3'd0, 32'hE); wcfg(3'd1, 32'h10); wcfg(3'd2, 32'd12);
      wcfg(3'd3, 32'd0); wcfg(3'd6, 32'h1);
      run(4, 1'b0, 3, "R4");
      wcfg(3'd5, 32'h2);

      // D: inverted pin polarity, 16-bit read, start while busy ignored (R8 R10)
      wcfg(3'd0, 32'h0); wcfg(3'd1, 32'h40); wcfg(3'd2, 32'd5);
      wcfg(3'd3, 32'd2); wcfg(3'd6, 32'h1);
      wcfg(3'd1, 32'h100); wcfg(3'd6, 32'h1);
      rcfg(3'd5, v); chk(v == 32'h1, "R10", "busy after second start", v, 32'h1);
      chk(dreq == 1'b0, "R8", "active-low request asserted", 32'(dreq), 32'd0);
      run(2, 1'b0, 3, "R10");
      chk(dreq == 1'b1, "R8", "active-low request idle", 32'(dreq), 32'd1);
      wcfg(3'd5, 32'h2);

      // G: 16-bit write of 12 bytes takes twice the beats of C (R3)
      wcfg(3'd0, 32'hD); wcfg(3'd1, 32'h60); wcfg(3'd2, 32'd12);
      wcfg(3'd3, 32'd0); wcfg(3'd6, 32'h1);
      run(7, 1'b0, 6, "R3");
      mem_compare("R6");
      wcfg(3'd5, 32'h2);

      // E: zero length finishes at once without request (R10)
      wcfg(3'd2, 32'd0); wcfg(3'd6, 32'h1);
      chk(dreq == 1'b0, "R10", "no request for zero length", 32'(dreq), 32'd0);
      rcfg(3'd5, v); chk(v == 32'h2, "R10", "zero length status", v, 32'h2);

      summary();
      $finish;
   end
endmodule